// File: doc/BRIEF.md
# Address-Bus Configuration Register Writer

This block takes configuration writes from a processor that places the write data on its address bus. It holds a 64-bit configuration register. Each write updates one byte of it. The byte is picked by a select field in the address, and the eight data bits sit in the address just above the two always-zero word-alignment bits.

A write counts only when three conditions hold:
- the upper address half equals a fixed base;
- a three-bit controller-select field equals the board's ID strap inputs;
- the processor reports supervisor mode.

Byte 0 is handled differently from the others. A four-bit command field in the middle of byte 0 either names one control action, or, when it is zero, lets the two test bits and the two low refresh-rate bits of byte 0 load. A nonzero command leaves those bits as they were.

The outputs are:
- the stored register, with the byte 0 command bits always read as zero;
- three decoded control flags;
- a one-cycle interrupt-acknowledge strobe;
- a one-cycle ready pulse for each accepted write.

Top module: `cfg_writer`

## Requirements
- R1: After reset the register reads all zeros, the data page-cache, instruction page-cache and interrupt-output flags are low, and the ready and acknowledge outputs are low.
- R2: The address layout is: bits 31:16 base (0x1F0F), bits 15:13 controller select, bits 12:10 byte select, bits 9:2 data byte, bits 1:0 zero. An accepted write to byte n (1 to 7) loads the data byte into register bits 8n+7:8n in the cycle after the request, and all other bytes keep their values.
- R3: A request made while the supervisor input is low changes no register bit or flag and produces no ready.
- R4: A request whose controller-select field differs from the ID strap changes nothing and produces no ready.
- R5: A request is also ignored if any of these holds: bits 31:16 differ from 0x1F0F, bits 1:0 are nonzero, or the request is a read.
- R6: A byte 0 write whose command field (data bits 5:2) is 0000 loads data bits 1:0 into register bits 1:0 and data bits 7:6 into register bits 7:6. Register bits 5:2 always read zero.
- R7: A byte 0 write with a nonzero command field leaves register bits 1:0 and 7:6 unchanged.
- R8: Command 0001 clears the data page-cache flag and 0010 sets it. Command 0011 clears the instruction page-cache flag and 0100 sets it.
- R9: Command 0110 sets the interrupt-output flag and 0111 clears it.
- R10: Command 0101 raises the acknowledge output for exactly the one cycle after the request and changes no flag.
- R11: Commands 1000 to 1111 change no flag, no register bit and raise no acknowledge, though the write is still accepted.
- R12: Ready is high in the cycle after each accepted write and low in every other cycle. An accepted write changes at most one flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| writeReq | input | 1 | High for a write, low for a read |
| supervisor | input | 1 | Processor is in supervisor mode |
| addrIn | input | 32 | Address bus carrying select fields and data |
| chipId | input | 3 | Controller ID strap |
| cfgReady | output | 1 | One-cycle ready for an accepted write |
| cfgReg | output | 64 | Stored configuration register |
| dataPcEn | output | 1 | Data page-cache enable flag |
| instrPcEn | output | 1 | Instruction page-cache enable flag |
| intOutEn | output | 1 | Interrupt output enable flag |
| timerAck | output | 1 | One-cycle interrupt acknowledge strobe |

## Verification
The following are all due on the first clock edge after the request cycle:
- the ready pulse;
- the acknowledge strobe;
- the register and flag updates.

Nothing in the block reacts in the request cycle itself, and nothing reacts later than that edge. The bench drives each request half a period before the edge that samples it and queues the expected state at that moment. The monitor compares the outputs shortly after the edge. Back-to-back requests therefore line up one compare per edge. This also checks that ready falls in the cycle after a rejected request.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int CFG_BYTES = 8;
  localparam int BYTE_W    = 8;
  localparam int OP_W      = 4;

  typedef struct packed {
    logic [CFG_BYTES-1:0] byteHit;
    logic [BYTE_W-1:0]    dataByte;
    logic                 opIdle;
    logic                 dcOff;
    logic                 dcOn;
    logic                 icOff;
    logic                 icOn;
    logic                 ieOn;
    logic                 ieOff;
  } cfg_strobe_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfgw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 3,
  parameter logic [15:0] BASE_HI = 16'h1F0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              writeReq,
  input  logic              supervisor,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ID_W-1:0]   chipId,
  output cfg_strobe_t       strobe,
  output logic              cfgReady,
  output logic              timerAck
);
  localparam int SEL_W    = $clog2(CFG_BYTES);
  localparam int DATA_LSB = 2;
  localparam int SEL_LSB  = DATA_LSB + BYTE_W;
  localparam int ID_LSB   = SEL_LSB + SEL_W;
  localparam int BASE_LSB = ID_LSB + ID_W;

  logic             hit;
  logic [SEL_W-1:0] byteSel;
  logic [OP_W-1:0]  opCode;
  logic [BYTE_W-1:0] dataByte;
  logic             byteZero;

  assign dataByte = addrIn[SEL_LSB-1:DATA_LSB];
  assign byteSel  = addrIn[ID_LSB-1:SEL_LSB];
  assign opCode   = dataByte[5:2];
  assign hit = reqValid && writeReq && supervisor
            && (addrIn[ADDR_W-1:BASE_LSB] == BASE_HI)
            && (addrIn[BASE_LSB-1:ID_LSB] == chipId)
            && (addrIn[DATA_LSB-1:0] == '0);

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_hit
    assign strobe.byteHit[i] = hit && (byteSel == SEL_W'(i));
  end

  assign byteZero        = strobe.byteHit[0];
  assign strobe.dataByte = dataByte;

  always_comb begin
    strobe.opIdle = 1'b0;
    strobe.dcOff  = 1'b0;
    strobe.dcOn   = 1'b0;
    strobe.icOff  = 1'b0;
    strobe.icOn   = 1'b0;
    strobe.ieOn   = 1'b0;
    strobe.ieOff  = 1'b0;
    if (byteZero) begin
      unique case (opCode)
        4'b0000: strobe.opIdle = 1'b1;
        4'b0001: strobe.dcOff  = 1'b1;
        4'b0010: strobe.dcOn   = 1'b1;
        4'b0011: strobe.icOff  = 1'b1;
        4'b0100: strobe.icOn   = 1'b1;
        4'b0110: strobe.ieOn   = 1'b1;
        4'b0111: strobe.ieOff  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReady <= 1'b0;
      timerAck <= 1'b0;
    end else begin
      cfgReady <= hit;
      timerAck <= byteZero && (opCode == 4'b0101);
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfgw_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  cfg_strobe_t                   strobe,
  output logic [CFG_BYTES*BYTE_W-1:0]   cfgReg,
  output logic                          dataPcEn,
  output logic                          instrPcEn,
  output logic                          intOutEn
);
  logic [1:0] testBits;
  logic [1:0] refreshLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testBits  <= '0;
      refreshLo <= '0;
    end else if (strobe.opIdle) begin
      testBits  <= strobe.dataByte[1:0];
      refreshLo <= strobe.dataByte[7:6];
    end
  end

  assign cfgReg[BYTE_W-1:0] = {refreshLo, 4'b0000, testBits};

  for (genvar b = 1; b < CFG_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] held;
    always_ff @(posedge clk) begin
      if (!rstN)                 held <= '0;
      else if (strobe.byteHit[b]) held <= strobe.dataByte;
    end
    assign cfgReg[b*BYTE_W +: BYTE_W] = held;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataPcEn  <= 1'b0;
      instrPcEn <= 1'b0;
      intOutEn  <= 1'b0;
    end else begin
      if (strobe.dcOn)       dataPcEn  <= 1'b1;
      else if (strobe.dcOff) dataPcEn  <= 1'b0;
      if (strobe.icOn)       instrPcEn <= 1'b1;
      else if (strobe.icOff) instrPcEn <= 1'b0;
      if (strobe.ieOn)       intOutEn  <= 1'b1;
      else if (strobe.ieOff) intOutEn  <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_writer.sv
module cfg_writer
  import cfgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 3,
  parameter logic [15:0] BASE_HI = 16'h1F0F
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        writeReq,
  input  logic                        supervisor,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic [ID_W-1:0]             chipId,
  output logic                        cfgReady,
  output logic [CFG_BYTES*BYTE_W-1:0] cfgReg,
  output logic                        dataPcEn,
  output logic                        instrPcEn,
  output logic                        intOutEn,
  output logic                        timerAck
);
  cfg_strobe_t strobe;

  cfg_addr_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W), .BASE_HI(BASE_HI)) i_decode (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .writeReq(writeReq),
    .supervisor(supervisor), .addrIn(addrIn), .chipId(chipId),
    .strobe(strobe), .cfgReady(cfgReady), .timerAck(timerAck)
  );

  cfg_store i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgReg(cfgReg),
    .dataPcEn(dataPcEn), .instrPcEn(instrPcEn), .intOutEn(intOutEn)
  );
endmodule

// File: rtl/cfg_writer_checker.sv
module cfg_writer_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        writeReq,
  input logic        supervisor,
  input logic [31:0] addrIn,
  input logic [2:0]  chipId,
  input logic        cfgReady,
  input logic [63:0] cfgReg,
  input logic        dataPcEn,
  input logic        instrPcEn,
  input logic        intOutEn,
  input logic        timerAck
);
  logic acc;
  logic acc0;
  assign acc = reqValid && writeReq && supervisor && (addrIn[31:16] == 16'h1F0F)
            && (addrIn[15:13] == chipId) && (addrIn[1:0] == 2'b00);
  assign acc0 = acc && (addrIn[12:10] == 3'd0);

  p_ready_after_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> cfgReady);
  p_no_ready_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !acc |=> !cfgReady);
  p_user_mode_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !supervisor) |=> ($stable(cfgReg) && $stable(dataPcEn)
      && $stable(instrPcEn) && $stable(intOutEn)));
  p_id_mismatch_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && addrIn[15:13] != chipId) |=> $stable(cfgReg));
  p_byte0_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (acc0 && addrIn[7:4] != 4'b0000) |=>
      (cfgReg[1:0] == $past(cfgReg[1:0]) && cfgReg[7:6] == $past(cfgReg[7:6])));
  p_single_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> ($countones({dataPcEn ^ $past(dataPcEn), instrPcEn ^ $past(instrPcEn),
                         intOutEn ^ $past(intOutEn)}) <= 1));
  p_ack_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    timerAck |-> $past(acc0 && addrIn[7:4] == 4'b0101));
endmodule

bind cfg_writer cfg_writer_checker i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .writeReq(writeReq),
  .supervisor(supervisor), .addrIn(addrIn), .chipId(chipId),
  .cfgReady(cfgReady), .cfgReg(cfgReg), .dataPcEn(dataPcEn),
  .instrPcEn(instrPcEn), .intOutEn(intOutEn), .timerAck(timerAck)
);

// File: tb/test_cfg_writer.sv
`timescale 1ns/1ps
module test_cfg_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        writeReq = 1'b0;
  logic        supervisor = 1'b0;
  logic [31:0] addrIn = '0;
  logic [2:0]  chipId = 3'd5;
  logic        cfgReady;
  logic [63:0] cfgReg;
  logic        dataPcEn, instrPcEn, intOutEn, timerAck;

  typedef struct packed {
    logic [63:0] reg64;
    logic        dc;
    logic        ic;
    logic        ie;
    logic        ack;
    logic        rdy;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    nTests = 0;
  int    nFail  = 0;
  bit    done   = 0;

  logic [63:0] mReg = '0;
  logic        mDc = 0, mIc = 0, mIe = 0;

  always #5 clk = ~clk;

  cfg_writer i_cfg_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .writeReq(writeReq),
    .supervisor(supervisor), .addrIn(addrIn), .chipId(chipId),
    .cfgReady(cfgReady), .cfgReg(cfgReg), .dataPcEn(dataPcEn),
    .instrPcEn(instrPcEn), .intOutEn(intOutEn), .timerAck(timerAck)
  );

  task automatic access(input logic sup, input logic [2:0] id, input logic [15:0] hi,
                        input logic [2:0] sel, input logic [7:0] data, input logic wr,
                        input logic [1:0] low, input string tag);
    logic ok;
    logic ack;
    exp_t e;
    @(negedge clk);
    reqValid   = 1'b1;
    writeReq   = wr;
    supervisor = sup;
    addrIn     = {hi, id, sel, data, low};
    ok  = wr && sup && (hi == 16'h1F0F) && (id == chipId) && (low == 2'b00);
    ack = 1'b0;
    if (ok) begin
      if (sel != 3'd0) mReg[sel*8 +: 8] = data;
      else begin
        case (data[5:2])
          4'b0000: begin mReg[1:0] = data[1:0]; mReg[7:6] = data[7:6]; end
          4'b0001: mDc = 1'b0;
          4'b0010: mDc = 1'b1;
          4'b0011: mIc = 1'b0;
          4'b0100: mIc = 1'b1;
          4'b0101: ack = 1'b1;
          4'b0110: mIe = 1'b1;
          4'b0111: mIe = 1'b0;
          default: ;
        endcase
      end
    end
    e = '{reg64: mReg, dc: mDc, ic: mIc, ie: mIe, ack: ack, rdy: ok};
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    writeReq = 1'b0;
    addrIn   = '0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = '{reg64: cfgReg, dc: dataPcEn, ic: instrPcEn, ie: intOutEn,
              ack: timerAck, rdy: cfgReady};
        nTests++;
        if (a !== e) begin
          nFail++;
          $display("FAIL %s: actual reg=%h dc=%b ic=%b ie=%b ack=%b rdy=%b expected reg=%h dc=%b ic=%b ie=%b ack=%b rdy=%b",
                   t, a.reg64, a.dc, a.ic, a.ie, a.ack, a.rdy,
                   e.reg64, e.dc, e.ic, e.ie, e.ack, e.rdy);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    nTests++;
    if ({cfgReg, dataPcEn, instrPcEn, intOutEn, timerAck, cfgReady} !== 69'd0) begin
      nFail++;
      $display("FAIL R1: actual reg=%h flags=%b%b%b ack=%b rdy=%b expected all zero",
               cfgReg, dataPcEn, instrPcEn, intOutEn, timerAck, cfgReady);
    end
    access(1, 3'd5, 16'h1F0F, 3'd3, 8'hA5, 1, 2'b00, "R2 byte3");
    access(1, 3'd5, 16'h1F0F, 3'd7, 8'h3C, 1, 2'b00, "R2 byte7");
    access(0, 3'd5, 16'h1F0F, 3'd3, 8'hFF, 1, 2'b00, "R3 user mode");
    access(1, 3'd4, 16'h1F0F, 3'd3, 8'hFF, 1, 2'b00, "R4 id mismatch");
    access(1, 3'd5, 16'h1F0E, 3'd3, 8'hFF, 1, 2'b00, "R5 base mismatch");
    access(1, 3'd5, 16'h1F0F, 3'd3, 8'hFF, 1, 2'b01, "R5 low bits");
    access(1, 3'd5, 16'h1F0F, 3'd3, 8'hFF, 0, 2'b00, "R5 read");
    idle();
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'hC2, 1, 2'b00, "R6 byte0 load");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h49, 1, 2'b00, "R7 R8 dc on masked");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h10, 1, 2'b00, "R8 ic on");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h18, 1, 2'b00, "R9 int on");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h14, 1, 2'b00, "R10 ack");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'hA9, 1, 2'b00, "R11 code 1010");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h3C, 1, 2'b00, "R11 code 1111");
    idle();
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h04, 1, 2'b00, "R8 dc off");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h0C, 1, 2'b00, "R8 ic off");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h1C, 1, 2'b00, "R9 int off");
    access(1, 3'd5, 16'h1F0F, 3'd1, 8'h81, 1, 2'b00, "R2 byte1");
    access(1, 3'd5, 16'h1F0F, 3'd0, 8'h01, 1, 2'b00, "R6 byte0 reload");
    idle();
    access(1, 3'd5, 16'h1F0F, 3'd5, 8'h5A, 0, 2'b00, "R12 no ready on read");
    idle();
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule